// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Coincidence Sync

This block takes one fast master clock and derives four slower clocks from it: three output banks (A, B, C) and a feedback clock. Each has its own even divide ratio and a 50% duty cycle. Every bank drives several identical copies. Two extra bank C outputs can each be set to follow the bank C clock or its complement. All dividers restart from a common phase when reset is released, so every clock rises together on the same master clock edge.

A sync flag, active low, watches banks A and C. It drops for the last P master clocks before a rising edge that the two banks share, where P is the period of the faster of the two banks. It returns high on that shared edge. The rule holds whether or not one ratio is a whole multiple of the other. The flag lets downstream logic prepare for the moment when the two domains line up.

Divide ratios and the invert selects are sampled only while reset is held. To change the setup, the system applies new ratios and pulses reset, which restarts every divider and the sync tracker together.

Top module: `mbdiv_top`

## Requirements
- R1: Each bank clock (every copy) and the feedback clock repeats every N master clocks, where N is that channel's effective ratio. It is high for the first N/2 master clocks of each period and low for the rest.
- R2: In the first cycle of the second master clock edge after reset is released, all bank clocks and the feedback clock rise together.
- R3: The effective ratio is the ratio input with bit 0 forced to 0. Any result below 2 is used as 2. So 7 acts as 6, 9 acts as 8, and 0 and 1 both act as 2. The largest effective ratio is 2^DW-2.
- R4: Selectable output i (i = 0, 1) equals the bank C clock when invSel[i] = 0 and the complement of the bank C clock when invSel[i] = 1.
- R5: syncN is 1 in every cycle in which banks A and C rise together.
- R6: Let P be the smaller of the A and C ratios and L their least common multiple. syncN is 0 in the P cycles immediately before each shared A/C rising edge. It is 1 in all other cycles. This holds for integer ratio pairs (such as 3:1) and non-integer pairs (such as 3:2 and 2:3).
- R7: While reset is held, and in the single cycle after its release, all bank and feedback clocks are 0 and syncN is 1.
- R8: A change to any ratio input while reset is deasserted has no effect on the outputs. The new ratio takes effect only after the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset; also samples ratios |
| ratioA | input | DW | Bank A divide ratio |
| ratioB | input | DW | Bank B divide ratio |
| ratioC | input | DW | Bank C divide ratio |
| ratioFb | input | DW | Feedback divide ratio |
| invSel | input | 2 | Invert select for the two selectable bank C outputs |
| qA | output | NA | Bank A clock copies |
| qB | output | NB | Bank B clock copies |
| qC | output | NC | Bank C clock copies |
| qCSel | output | 2 | Selectable (plain or inverted) bank C outputs |
| qFb | output | 1 | Feedback clock |
| syncN | output | 1 | Active-low warning of the next shared A/C rising edge |

## Verification
The bench uses the default parameters: DW = 5, four copies on banks A and B, and two plain copies on bank C. With DW = 5 the ratios 2 to 30 can be reached, including the maximum ratio of 30 at the top of that range.

The bench drives several A/C ratio pairs:
- 3:1 and equal ratios, where the two banks coincide at whole-number multiples;
- 3:2 and 2:3, where the shared edges are spaced by a least common multiple that is larger than either period, so the sync window has to be found by lookahead;
- odd and out-of-range raw ratios, and ratio changes made mid-run without a reset.

// File: rtl/mbdiv_pkg.sv
package mbdiv_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_C   = 2;
  localparam int CH_FB  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // restart every phase counter
    logic run;   // phases valid, sync decision enabled
  } ctrl_strobe_t;

endpackage

// File: rtl/mbdiv_divider.sv
module mbdiv_divider #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          load,
  input  logic [DW-1:0] ratio,
  output logic          clkOut
);

  localparam logic [DW-1:0] ONE = DW'(1);

  // phase counts down ratio..1; value ratio marks the rising edge
  logic [DW-1:0] phase;

  always_ff @(posedge clk) begin
    if (load)              phase <= ONE;
    else if (phase == ONE) phase <= ratio;
    else                   phase <= phase - ONE;
  end

  assign clkOut = phase > (ratio >> 1);

endmodule

// File: rtl/mbdiv_coinc.sv
module mbdiv_coinc #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          load,
  input  logic          run,
  input  logic [DW-1:0] ratioA,
  input  logic [DW-1:0] ratioC,
  output logic          syncN
);

  localparam logic [DW-1:0] ONE = DW'(1);

  // each phase equals the master clocks left until that bank next rises
  logic [DW-1:0] phaseA;
  logic [DW-1:0] phaseC;
  logic          edgeBoth;

  always_ff @(posedge clk) begin
    if (load) begin
      phaseA <= ONE;
      phaseC <= ONE;
    end else begin
      phaseA <= (phaseA == ONE) ? ratioA : phaseA - ONE;
      phaseC <= (phaseC == ONE) ? ratioC : phaseC - ONE;
    end
  end

  assign edgeBoth = (phaseA == ratioA) && (phaseC == ratioC);

  // equal time-to-next-edge means the next edges of A and C coincide,
  // and the faster bank bounds that distance by its own period
  assign syncN = !run || edgeBoth || (phaseA != phaseC);

endmodule

// File: rtl/mbdiv_ctrl.sv
module mbdiv_ctrl
  import mbdiv_pkg::*;
#(
  parameter int DW = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DW-1:0]                ratioAIn,
  input  logic [DW-1:0]                ratioBIn,
  input  logic [DW-1:0]                ratioCIn,
  input  logic [DW-1:0]                ratioFbIn,
  output logic [NUM_CH-1:0][DW-1:0]    ratioQ,
  output ctrl_strobe_t                 strobe
);

  localparam logic [DW-1:0] TWO = DW'(2);

  logic [NUM_CH-1:0][DW-1:0] rawRatio;
  logic                      live;
  logic                      runQ;

  function automatic logic [DW-1:0] evenRatio(input logic [DW-1:0] r);
    logic [DW-1:0] e;
    e = {r[DW-1:1], 1'b0};
    if (e < TWO) e = TWO;
    return e;
  endfunction

  always_comb begin
    rawRatio[CH_A]  = ratioAIn;
    rawRatio[CH_B]  = ratioBIn;
    rawRatio[CH_C]  = ratioCIn;
    rawRatio[CH_FB] = ratioFbIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) ratioQ[i] <= evenRatio(rawRatio[i]);
      live <= 1'b0;
      runQ <= 1'b0;
    end else begin
      live <= 1'b1;
      runQ <= live;
    end
  end

  assign strobe.load = !live;
  assign strobe.run  = runQ;

endmodule

// File: rtl/mbdiv_datapath.sv
module mbdiv_datapath
  import mbdiv_pkg::*;
#(
  parameter int DW = 5,
  parameter int NA = 4,
  parameter int NB = 4,
  parameter int NC = 2
) (
  input  logic                      clk,
  input  ctrl_strobe_t              strobe,
  input  logic [NUM_CH-1:0][DW-1:0] ratioQ,
  input  logic [1:0]                invSel,
  output logic [NA-1:0]             qA,
  output logic [NB-1:0]             qB,
  output logic [NC-1:0]             qC,
  output logic [1:0]                qCSel,
  output logic                      qFb,
  output logic                      syncN
);

  logic [NUM_CH-1:0] chanClk;

  for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
    mbdiv_divider #(.DW(DW)) div_i (
      .clk    (clk),
      .load   (strobe.load),
      .ratio  (ratioQ[g]),
      .clkOut (chanClk[g])
    );
  end

  mbdiv_coinc #(.DW(DW)) coinc_i (
    .clk    (clk),
    .load   (strobe.load),
    .run    (strobe.run),
    .ratioA (ratioQ[CH_A]),
    .ratioC (ratioQ[CH_C]),
    .syncN  (syncN)
  );

  assign qA    = {NA{chanClk[CH_A]}};
  assign qB    = {NB{chanClk[CH_B]}};
  assign qC    = {NC{chanClk[CH_C]}};
  assign qCSel = {2{chanClk[CH_C]}} ^ invSel;
  assign qFb   = chanClk[CH_FB];

endmodule

// File: rtl/mbdiv_top.sv
module mbdiv_top
  import mbdiv_pkg::*;
#(
  parameter int DW = 5,
  parameter int NA = 4,
  parameter int NB = 4,
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] ratioA,
  input  logic [DW-1:0] ratioB,
  input  logic [DW-1:0] ratioC,
  input  logic [DW-1:0] ratioFb,
  input  logic [1:0]    invSel,
  output logic [NA-1:0] qA,
  output logic [NB-1:0] qB,
  output logic [NC-1:0] qC,
  output logic [1:0]    qCSel,
  output logic          qFb,
  output logic          syncN
);

  logic [NUM_CH-1:0][DW-1:0] ratioQ;
  ctrl_strobe_t              strobe;

  mbdiv_ctrl #(.DW(DW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ratioAIn  (ratioA),
    .ratioBIn  (ratioB),
    .ratioCIn  (ratioC),
    .ratioFbIn (ratioFb),
    .ratioQ    (ratioQ),
    .strobe    (strobe)
  );

  mbdiv_datapath #(.DW(DW), .NA(NA), .NB(NB), .NC(NC)) dp_i (
    .clk    (clk),
    .strobe (strobe),
    .ratioQ (ratioQ),
    .invSel (invSel),
    .qA     (qA),
    .qB     (qB),
    .qC     (qC),
    .qCSel  (qCSel),
    .qFb    (qFb),
    .syncN  (syncN)
  );

endmodule

// File: rtl/mbdiv_checker.sv
module mbdiv_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] invSel,
  input logic       aClk,
  input logic       cClk,
  input logic [1:0] qCSel,
  input logic       syncN
);

  logic [7:0] hiCnt;
  logic [7:0] loCnt;
  logic [7:0] hiLast;
  logic       seenFall;

  // measure the high and low phases of bank A
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt    <= '0;
      loCnt    <= '0;
      hiLast   <= '0;
      seenFall <= 1'b0;
    end else if (aClk) begin
      hiCnt <= hiCnt + 8'd1;
      loCnt <= '0;
    end else begin
      loCnt <= loCnt + 8'd1;
      hiCnt <= '0;
      if (hiCnt != 8'd0) begin
        hiLast   <= hiCnt;
        seenFall <= 1'b1;
      end
    end
  end

  AST_HALF_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (aClk && loCnt != 8'd0 && seenFall) |-> (hiLast == loCnt)); // R1

  AST_SYNC_HIGH_AT_COINC: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(aClk) && $rose(cClk)) |-> syncN); // R5

  AST_SYNC_LOW_UNTIL_COINC: assert property (@(posedge clk) disable iff (!rstN)
    !syncN |=> (!syncN || ($rose(aClk) && $rose(cClk)))); // R6

  AST_SEL0_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cClk) && $stable(invSel)) |-> (invSel[0] ? $fell(qCSel[0]) : $rose(qCSel[0]))); // R4

  AST_SEL1_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cClk) && $stable(invSel)) |-> (invSel[1] ? $fell(qCSel[1]) : $rose(qCSel[1]))); // R4

endmodule

bind mbdiv_top mbdiv_checker chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .invSel (invSel),
  .aClk   (qA[0]),
  .cClk   (qC[0]),
  .qCSel  (qCSel),
  .syncN  (syncN)
);

// File: tb/mbdiv_top_tb_top.sv
module mbdiv_top_tb_top;

  localparam int DW = 5;
  localparam int NA = 4;
  localparam int NB = 4;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] ratioA = DW'(2);
  logic [DW-1:0] ratioB = DW'(2);
  logic [DW-1:0] ratioC = DW'(2);
  logic [DW-1:0] ratioFb = DW'(2);
  logic [1:0]    invSel = 2'b00;
  logic [NA-1:0] qA;
  logic [NB-1:0] qB;
  logic [NC-1:0] qC;
  logic [1:0]    qCSel;
  logic          qFb;
  logic          syncN;

  always #4 clk = ~clk;  // 125 MHz

  mbdiv_top #(.DW(DW), .NA(NA), .NB(NB), .NC(NC)) dut_i (
    .clk(clk), .rstN(rstN), .ratioA(ratioA), .ratioB(ratioB), .ratioC(ratioC),
    .ratioFb(ratioFb), .invSel(invSel), .qA(qA), .qB(qB), .qC(qC),
    .qCSel(qCSel), .qFb(qFb), .syncN(syncN)
  );

  typedef struct {
    logic       a;
    logic       b;
    logic       c;
    logic       fb;
    logic [1:0] sel;
    logic       sync;
    string      clkTag;
    string      syncTag;
  } exp_t;

  exp_t expQ[$];
  int   tests = 0;
  int   fails = 0;
  bit   mon = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int effRatio(input int r);  // R3 rule
    int e;
    e = r & ~1;
    if (e < 2) e = 2;
    return e;
  endfunction

  function automatic int gcd(input int x, input int y);
    int a = x;
    int b = y;
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // monitor: pop and compare one expected item per master clock
  always @(negedge clk) begin
    exp_t e;
    if (mon && expQ.size() != 0) begin
      e = expQ.pop_front();
      check(qA == {NA{e.a}}, e.clkTag, "qA", int'(qA), int'({NA{e.a}}));
      check(qB == {NB{e.b}}, e.clkTag, "qB", int'(qB), int'({NB{e.b}}));
      check(qC == {NC{e.c}}, e.clkTag, "qC", int'(qC), int'({NC{e.c}}));
      check(qFb == e.fb, e.clkTag, "qFb", int'(qFb), int'(e.fb));
      check(qCSel == e.sel, "R4", "qCSel", int'(qCSel), int'(e.sel));
      check(syncN == e.sync, e.syncTag, "syncN", int'(syncN), int'(e.sync));
    end
  end

  // driver: reset with the given setup, push the expected trace, let it run
  task automatic runCase(input int ra, input int rb, input int rc, input int rf,
                         input logic [1:0] inv, input int n, input string tag,
                         input int chgA, input int chgC);
    int a, b, c, f, l, p;
    exp_t e;
    @(negedge clk);
    ratioA = DW'(ra); ratioB = DW'(rb); ratioC = DW'(rc); ratioFb = DW'(rf);
    invSel = inv;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R7: held in reset
    check(qA == '0 && qB == '0 && qC == '0 && qFb == 1'b0, "R7", "clocks in reset",
          int'({qA, qB, qC, qFb}), 0);
    check(syncN == 1'b1, "R7", "syncN in reset", int'(syncN), 1);
    check(qCSel == inv, "R4", "qCSel in reset", int'(qCSel), int'(inv));
    rstN = 1'b1;
    a = effRatio(ra); b = effRatio(rb); c = effRatio(rc); f = effRatio(rf);
    l = (a / gcd(a, c)) * c;
    p = (a < c) ? a : c;
    // cycle right after release: all low, sync high (R7)
    e.a = 1'b0; e.b = 1'b0; e.c = 1'b0; e.fb = 1'b0;
    e.sel = inv; e.sync = 1'b1; e.clkTag = "R7"; e.syncTag = "R7";
    expQ.push_back(e);
    for (int k = 0; k < n; k++) begin
      int m = k % l;
      e.a  = (k % a) < (a / 2);
      e.b  = (k % b) < (b / 2);
      e.c  = (k % c) < (c / 2);
      e.fb = (k % f) < (f / 2);
      e.sel = {e.c ^ inv[1], e.c ^ inv[0]};
      e.sync = (m == 0) ? 1'b1 : (((l - m) <= p) ? 1'b0 : 1'b1);
      if (tag != "") begin
        e.clkTag = tag; e.syncTag = tag;
      end else begin
        e.clkTag = (k == 0) ? "R2" : "R1";
        e.syncTag = (m == 0) ? "R5" : "R6";
      end
      expQ.push_back(e);
    end
    @(posedge clk);
    mon = 1'b1;
    if (chgA != 0) begin
      repeat (10) @(posedge clk);
      #1;
      ratioA = DW'(chgA);
      ratioC = DW'(chgC);
    end
    while (expQ.size() != 0) @(posedge clk);
    @(posedge clk);
    mon = 1'b0;
  endtask

  initial begin
    runCase(6, 4, 2, 8, 2'b10, 40, "", 0, 0);     // A:C = 3:1
    runCase(6, 10, 4, 12, 2'b01, 40, "", 0, 0);   // A:C = 3:2
    runCase(4, 6, 4, 2, 2'b00, 24, "", 0, 0);     // equal ratios
    runCase(4, 8, 6, 16, 2'b11, 40, "", 0, 0);    // A:C = 2:3, C slower
    runCase(7, 0, 1, 9, 2'b11, 30, "R3", 0, 0);   // odd / too small raw ratios
    runCase(6, 4, 4, 6, 2'b01, 40, "R8", 10, 8);  // mid-run change ignored
    runCase(10, 4, 8, 6, 2'b10, 48, "R8", 0, 0);  // new ratios after reset
    runCase(30, 2, 2, 14, 2'b00, 64, "", 0, 0);   // maximum ratio
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule